// File: doc/BRIEF.md
# Serial Parity Bit Inserter

This block frames a serial bit stream into messages of three data bits and follows every message with one extra bit, chosen so that the four-bit group carries an even number of ones. Data bits enter one per clock on `in_bit`, qualified by `in_valid`. The block emits each accepted bit one cycle later on `out_bit` with `out_valid` high. Once the third bit of a message has been accepted, the following cycle is a parity slot. In that slot the block drives the accumulated parity on the output and holds `in_ready` low, so no new data bit is taken.

A small tracker follows the bit position within the message and the current phase (data or parity slot). A one-bit accumulator keeps the running exclusive-or of the accepted bits and clears as the slot is emitted, so each message starts from zero. A registered output stage combines the two sources. The message length is a parameter (`MSG_BITS`, default 3). Reset is synchronous and active high.

Top module: `par_slot_inserter`

## Requirements
- R1: While `rst` is high at a clock edge, the block afterwards shows `out_valid` = 0, `out_bit` = 0 and `in_ready` = 1.
- R2: A data bit accepted at an edge (`in_valid` = 1 and `in_ready` = 1) appears on `out_bit`, with `out_valid` = 1, directly after that edge.
- R3: In the cycle after the third accepted bit of a message, the block presents a parity slot: `out_valid` = 1, and `out_bit` makes the exclusive-or of the three data bits and the slot bit equal 0.
- R4: `in_ready` is 0 for exactly the one cycle of the parity slot. A bit offered with `in_valid` = 1 during that cycle is not consumed and never appears on the output.
- R5: Parity restarts at 0 for every message, so the slot bit of a message depends only on that message's three bits.
- R6: When `in_ready` = 1 and `in_valid` = 0 at an edge, the next cycle shows `out_valid` = 0 and `out_bit` = 0. Bit position and running parity are kept across the gap.
- R7: With `in_valid` held at 1, `out_valid` is 1 in every cycle, covering all four slots of each group, and consecutive groups follow back to back.
- R8: Asserting `rst` in the middle of a message discards it: the next accepted bit is bit zero of a new message, with parity starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Serial data bit |
| in_valid | input | 1 | `in_bit` carries a data bit this cycle |
| in_ready | output | 1 | Block can take a data bit this cycle (low in the parity slot) |
| out_bit | output | 1 | Serial output: echoed data bit or inserted parity bit |
| out_valid | output | 1 | `out_bit` is meaningful this cycle |

## Verification
If the position tracker is wrong, the parity slot lands early or late. This shows as a drop of `in_ready` in the wrong cycle and a group of the wrong length, visible within one message. If the running parity is wrong, for example because it is not cleared or because it takes the bit offered during the slot, the slot bit is wrong on the first message whose data exposes the error. That shows up one cycle after the third bit. A wrong output stage shows as a missing echo, or as a stray `out_valid` during gaps, one cycle after the input that should have caused or suppressed it.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef enum logic [0:0] {
    PH_DATA = 1'b0,
    PH_SLOT = 1'b1
  } phase_t;

  // one step of the running even-parity accumulation
  function automatic logic par_step(input logic acc, input logic din);
    return acc ^ din;
  endfunction

  // wrap-around advance of the message bit index
  function automatic int unsigned pos_step(input int unsigned cur, input int unsigned last);
    return (cur == last) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/pis_slot_tracker.sv
module pis_slot_tracker
  import pis_pkg::*;
#(
  parameter int MSG_BITS = 3,
  parameter int POS_W    = (MSG_BITS > 1) ? $clog2(MSG_BITS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic at_last,
  output logic in_slot
);

  localparam int unsigned LAST = MSG_BITS - 1;

  phase_t           phase_q;
  logic [POS_W-1:0] pos_q;

  assign in_slot = (phase_q == PH_SLOT);
  assign at_last = (phase_q == PH_DATA) && (pos_q == POS_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_DATA;
      pos_q   <= '0;
    end else if (in_slot) begin
      phase_q <= PH_DATA;
    end else if (take) begin
      pos_q <= POS_W'(pos_step(int'(pos_q), LAST));
      if (at_last) phase_q <= PH_SLOT;
    end
  end

endmodule

// File: rtl/pis_parity_acc.sv
module pis_parity_acc
  import pis_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic take,
  input  logic din,
  output logic par
);

  always_ff @(posedge clk) begin
    if (rst || clr) par <= 1'b0;
    else if (take)  par <= par_step(par, din);
  end

endmodule

// File: rtl/pis_out_stage.sv
module pis_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic slot,
  input  logic par,
  input  logic take,
  input  logic din,
  output logic q_bit,
  output logic q_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_bit   <= 1'b0;
      q_valid <= 1'b0;
    end else if (slot) begin
      q_bit   <= par;
      q_valid <= 1'b1;
    end else if (take) begin
      q_bit   <= din;
      q_valid <= 1'b1;
    end else begin
      q_bit   <= 1'b0;
      q_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/par_slot_inserter.sv
module par_slot_inserter #(
  parameter int MSG_BITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic in_ready,
  output logic out_bit,
  output logic out_valid
);

  localparam int POS_W = (MSG_BITS > 1) ? $clog2(MSG_BITS) : 1;

  // named internal events, observed by the bound checker
  logic acc_evt;
  logic last_evt;
  logic slot_evt;
  logic at_last;
  logic run_par;

  assign in_ready = !slot_evt;
  assign acc_evt  = in_valid && in_ready;
  assign last_evt = acc_evt && at_last;

  pis_slot_tracker #(.MSG_BITS(MSG_BITS), .POS_W(POS_W)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .take    (acc_evt),
    .at_last (at_last),
    .in_slot (slot_evt)
  );

  pis_parity_acc u_par (
    .clk  (clk),
    .rst  (rst),
    .clr  (slot_evt),
    .take (acc_evt),
    .din  (in_bit),
    .par  (run_par)
  );

  pis_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .slot    (slot_evt),
    .par     (run_par),
    .take    (acc_evt),
    .din     (in_bit),
    .q_bit   (out_bit),
    .q_valid (out_valid)
  );

endmodule

// File: rtl/pis_chk.sv
module pis_chk #(
  parameter int MSG_BITS = 3
) (
  input logic clk,
  input logic rst,
  input logic in_bit,
  input logic in_valid,
  input logic in_ready,
  input logic out_bit,
  input logic out_valid,
  input logic acc_evt,
  input logic last_evt,
  input logic slot_evt
);

  localparam int CW = $clog2(MSG_BITS + 1);

  // independent count of emitted slots within a group, and their parity
  logic [CW-1:0] seen;
  logic          grp_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= '0;
      grp_x <= 1'b0;
    end else if (out_valid) begin
      if (seen == CW'(MSG_BITS)) begin
        seen  <= '0;
        grp_x <= 1'b0;
      end else begin
        seen  <= seen + 1'b1;
        grp_x <= grp_x ^ out_bit;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!out_valid && !out_bit && in_ready));

  // R2
  echo_bit_chk: assert property (@(posedge clk) disable iff (rst)
    acc_evt |=> (out_valid && out_bit == $past(in_bit)));

  // R3
  even_group_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen == CW'(MSG_BITS)) |-> (out_bit == grp_x));

  // R3
  slot_valid_chk: assert property (@(posedge clk) disable iff (rst)
    slot_evt |=> out_valid);

  // R4
  stall_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    last_evt |=> !in_ready);

  // R4
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  // R6
  gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (!out_valid && !out_bit));

endmodule

bind par_slot_inserter pis_chk #(.MSG_BITS(MSG_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_bit    (in_bit),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_bit   (out_bit),
  .out_valid (out_valid),
  .acc_evt   (acc_evt),
  .last_evt  (last_evt),
  .slot_evt  (slot_evt)
);

// File: tb/sim_par_slot_inserter.sv
module sim_par_slot_inserter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_bit, out_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  par_slot_inserter #(.MSG_BITS(3)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_bit    (in_bit),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_bit   (out_bit),
    .out_valid (out_valid)
  );

  // per cycle: {in_valid, in_bit, exp in_ready, exp out_valid, exp out_bit}
  localparam int NV = 18;
  localparam logic [4:0] VEC [NV] = '{
    5'b11111, 5'b10110, 5'b11011, 5'b11110, 5'b11111, 5'b01100,
    5'b10110, 5'b10010, 5'b00111, 5'b10110, 5'b10110, 5'b10010,
    5'b10110, 5'b11111, 5'b11111, 5'b11011, 5'b00111, 5'b01100
  };

  task automatic check(input string tag, input logic rdy, input logic ov, input logic ob);
    n_chk++;
    if (in_ready !== rdy || out_valid !== ov || out_bit !== ob) begin
      n_bad++;
      $display("FAIL %s: ready/valid/bit = %b%b%b expected %b%b%b",
               tag, in_ready, out_valid, out_bit, rdy, ov, ob);
    end
  endtask

  task automatic step(input logic v, input logic b, input string tag,
                      input logic rdy, input logic ov, input logic ob);
    in_valid = v;
    in_bit   = b;
    @(posedge clk);
    @(negedge clk);
    check(tag, rdy, ov, ob);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: run did not end, cycles 5000 expected fewer");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic prev_rdy;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;

    // table walk: R2 echo, R3 slot parity, R4 stall, R5 per-message restart, R6 gaps
    prev_rdy = 1'b1;
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (!prev_rdy)          tag = "R3";
      else if (!VEC[i][4])    tag = "R6";
      else if (!VEC[i][2])    tag = "R4";
      else if (i >= 9)        tag = "R5";
      else                    tag = "R2";
      step(VEC[i][4], VEC[i][3], tag, VEC[i][2], VEC[i][1], VEC[i][0]);
      prev_rdy = VEC[i][2];
    end

    // R8: partial message 1,0 then reset, then 0,0,0 must close with parity 0
    step(1'b1, 1'b1, "R8", 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, "R8", 1'b1, 1'b1, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b0, "R8", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    step(1'b1, 1'b0, "R8", 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, "R8", 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, "R8", 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, "R8", 1'b1, 1'b1, 1'b0);

    // R7: valid held high over two groups, bit offered in the slot is dropped (R4)
    step(1'b1, 1'b0, "R7", 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, "R7", 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, "R7", 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, "R7", 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, "R7", 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, "R7", 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, "R7", 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, "R7", 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, "R6", 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule